// File: doc/BRIEF.md
# Hash Input Word Feeder

This block sits on the user-clock side of a register file and hands 64-bit message words to a hash core over a valid/ready pair. Software builds each word from two 32-bit writes: the low half first, then the high half. The write to the high half launches the word toward the core. A loadable byte-length counter tracks how much of the message is still to be sent. From that count the block raises the last-word flag and forms the byte-enable mask of a partial final word.

For throughput tests a constant-fill mode drives a preloaded alternate word on its own. It keeps valid high until the programmed length is used up, so the CPU issues no write per word. Clearing the mode before that point stops the stream and freezes the count. Software can read back a ready flag before each word, along with the current mask and the remaining length.

Register selects on `wr_addr_i` are: 0 data low, 1 data high, 2 alternate low, 3 alternate high, 4 byte length, 5 mode (bit 0 enables constant fill).

Top module: `hash_word_feeder`

## Requirements
- R1: In normal mode `word_o` equals {last data-high write (addr 1), last data-low write (addr 0)}, with the high half in bits 63:32.
- R2: Writes to addresses 0, 2 and 3 never assert `valid_o`; only a write to address 1 does, in the cycle after the write.
- R3: A write to address 4 loads the remaining length, visible on `len_o` the next cycle. Each cycle with `valid_o` and `core_ready_i` both high lowers it by 8, saturating at 0. A length load wins over a decrement in the same cycle.
- R4: `last_o` is high exactly when `valid_o` is high and the remaining length is 8 or less.
- R5: When the remaining length is 8 or less and its low 3 bits n are nonzero, `byte_en_o` has bits 0 to n-1 set and the rest clear. In every other case it is 0xFF.
- R6: With mode bit 0 set, `valid_o` is high whenever the remaining length is nonzero, and `word_o` carries {alternate high, alternate low}. Both hold steady while `core_ready_i` is low.
- R7: In normal mode a launched word stays valid until accepted, and `valid_o` falls in the cycle after acceptance unless a new high write arrives.
- R8: `ready_o` is high only when `core_ready_i` is high, the mode is normal and no launched word is pending.
- R9: Clearing mode bit 0 before the length is used up drops `valid_o` and leaves `len_o` unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 32 | Write data |
| core_ready_i | input | 1 | Core can take a word |
| word_o | output | 64 | Word to the core |
| valid_o | output | 1 | Word valid |
| last_o | output | 1 | Final word of the message |
| byte_en_o | output | 8 | Byte enables of the current word |
| ready_o | output | 1 | Software may write the next word |
| len_o | output | 32 | Remaining byte length |

## Verification
The bench walks lengths on both sides of the 8-byte boundary, including 8, 9, 16, 1 and 0x100. A feeder that compared against 8 with the wrong sense would mark the last word one word too early or too late, and a mask built from the raw low bits would send 0x00 instead of 0xFF for whole final words. Constant fill is run to exhaustion with the word count checked, which catches a counter that wraps below zero and streams forever. It is also aborted mid-stream to catch a count that keeps running or a valid that lingers. Writes to the low and alternate halves are observed on `valid_o` to catch a strobe fired from the wrong register.

// File: rtl/hash_feed_pkg.sv
package hash_feed_pkg;
  typedef enum logic [2:0] {
    REG_LO     = 3'd0,
    REG_HI     = 3'd1,
    REG_ALT_LO = 3'd2,
    REG_ALT_HI = 3'd3,
    REG_LEN    = 3'd4,
    REG_MODE   = 3'd5
  } feed_reg_e;
endpackage

// File: rtl/hash_feed_regs.sv
module hash_feed_regs
  import hash_feed_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              usr_accept_i,
  output logic [2*DATA_W-1:0] usr_word_o,
  output logic [2*DATA_W-1:0] alt_word_o,
  output logic              usr_valid_o,
  output logic              const_en_o
);
  // bank 0: user word, bank 1: alternate constant word
  logic [DATA_W-1:0] half_q [2][2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam logic [2:0] ADDR = 3'(2 * b + h);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         half_q[b][h] <= '0;
        else if (wr_en_i && wr_addr_i == ADDR) half_q[b][h] <= wr_data_i;
      end
    end
  end

  assign usr_word_o = {half_q[0][1], half_q[0][0]};
  assign alt_word_o = {half_q[1][1], half_q[1][0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_valid_o <= 1'b0;
      const_en_o  <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_HI) usr_valid_o <= 1'b1;
      else if (usr_accept_i)              usr_valid_o <= 1'b0;
      if (wr_en_i && wr_addr_i == REG_MODE) const_en_o <= wr_data_i[0];
    end
  end
endmodule

// File: rtl/hash_feed_len.sv
module hash_feed_len #(
  parameter int LEN_W = 32,
  parameter int BYTES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_val_i,
  input  logic             accept_i,
  output logic [LEN_W-1:0] rem_o,
  output logic             tail_o,
  output logic [BYTES-1:0] mask_o
);
  localparam int IDX_W = $clog2(BYTES);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BYTES);

  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] frac;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (load_i)   rem_q <= load_val_i;
    else if (accept_i) rem_q <= (rem_q > STEP) ? rem_q - STEP : '0;
  end

  assign rem_o  = rem_q;
  assign tail_o = (rem_q <= STEP);
  assign frac   = rem_q[IDX_W-1:0];

  for (genvar i = 0; i < BYTES; i++) begin : g_mask
    assign mask_o[i] = !tail_o || (frac == '0) || (IDX_W'(i) < frac);
  end
endmodule

// File: rtl/hash_word_feeder.sv
module hash_word_feeder
  import hash_feed_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  localparam int WORD_W = 2 * DATA_W,
  localparam int BYTES  = WORD_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              core_ready_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              last_o,
  output logic [BYTES-1:0]  byte_en_o,
  output logic              ready_o,
  output logic [LEN_W-1:0]  len_o
);
  logic [WORD_W-1:0] usr_word, alt_word;
  logic usr_valid, const_en, accept, tail;

  assign accept = valid_o && core_ready_i;

  hash_feed_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .usr_accept_i (accept && !const_en),
    .usr_word_o   (usr_word),
    .alt_word_o   (alt_word),
    .usr_valid_o  (usr_valid),
    .const_en_o   (const_en)
  );

  hash_feed_len #(.LEN_W(LEN_W), .BYTES(BYTES)) u_len (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_en_i && wr_addr_i == REG_LEN),
    .load_val_i (wr_data_i[LEN_W-1:0]),
    .accept_i   (accept),
    .rem_o      (len_o),
    .tail_o     (tail),
    .mask_o     (byte_en_o)
  );

  assign valid_o = const_en ? (len_o != '0) : usr_valid;
  assign word_o  = const_en ? alt_word : usr_word;
  assign last_o  = valid_o && tail;
  assign ready_o = core_ready_i && !usr_valid && !const_en;
endmodule

// File: rtl/hash_word_feeder_chk.sv
module hash_word_feeder_chk
  import hash_feed_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 32,
  localparam int WORD_W = 2 * DATA_W,
  localparam int BYTES  = WORD_W / 8,
  localparam int IDX_W  = $clog2(BYTES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [2:0]        wr_addr_i,
  input logic              core_ready_i,
  input logic [WORD_W-1:0] word_o,
  input logic              valid_o,
  input logic              last_o,
  input logic [BYTES-1:0]  byte_en_o,
  input logic              ready_o,
  input logic [LEN_W-1:0]  len_o,
  input logic              const_en
);
  localparam logic [LEN_W-1:0] STEP = LEN_W'(BYTES);
  logic len_wr, hi_or_mode_wr;
  assign len_wr        = wr_en_i && wr_addr_i == REG_LEN;
  assign hi_or_mode_wr = wr_en_i && (wr_addr_i == REG_HI || wr_addr_i == REG_MODE);

  p_len_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && core_ready_i && len_o > STEP && !len_wr |=> len_o == $past(len_o) - STEP);

  p_last_empties_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && core_ready_i && !len_wr |=> len_o == '0);

  p_mask_part_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && len_o[IDX_W-1:0] != '0 |-> $countones(byte_en_o) == int'(len_o[IDX_W-1:0]));

  p_mask_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o |-> &byte_en_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    const_en && valid_o && !core_ready_i && !wr_en_i |=> valid_o && $stable(word_o));

  p_quiet_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !const_en && !valid_o && wr_en_i && wr_addr_i != REG_HI && wr_addr_i != REG_MODE |=> !valid_o);

  p_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !const_en && valid_o && core_ready_i && !hi_or_mode_wr |=> !valid_o);

  p_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !valid_o && core_ready_i);

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !const_en && !valid_o && !wr_en_i |=> $stable(len_o));
endmodule

bind hash_word_feeder hash_word_feeder_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .core_ready_i (core_ready_i),
  .word_o       (word_o),
  .valid_o      (valid_o),
  .last_o       (last_o),
  .byte_en_o    (byte_en_o),
  .ready_o      (ready_o),
  .len_o        (len_o),
  .const_en     (const_en)
);

// File: tb/hash_word_feeder_tb.sv
module hash_word_feeder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        core_ready = 1'b0;
  logic [63:0] word;
  logic        valid, last, ready;
  logic [7:0]  byte_en;
  logic [31:0] len;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  hash_word_feeder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .core_ready_i(core_ready), .word_o(word),
    .valid_o(valid), .last_o(last), .byte_en_o(byte_en), .ready_o(ready),
    .len_o(len)
  );

  // {length, expected byte enable, expected last}
  localparam logic [40:0] VEC [0:7] = '{
    {32'd20,    8'hFF, 1'b0},
    {32'd8,     8'hFF, 1'b1},
    {32'd5,     8'h1F, 1'b1},
    {32'd1,     8'h01, 1'b1},
    {32'd9,     8'hFF, 1'b0},
    {32'd16,    8'hFF, 1'b0},
    {32'd3,     8'h07, 1'b1},
    {32'h100,   8'hFF, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset valid", 64'(valid), 64'd0);
    check("R3 reset len", 64'(len), 64'd0);
    check("R4 reset last", 64'(last), 64'd0);
    check("R8 reset ready", 64'(ready), 64'd0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] l;
      l = VEC[i][40:9];
      wr(3'd4, l);
      check("R3 len load", 64'(len), 64'(l));
      wr(3'd0, 32'h1000_0000 + i);
      check("R2 low write no valid", 64'(valid), 64'd0);
      wr(3'd1, 32'hA500_0000 + i);
      check("R2 high write valid", 64'(valid), 64'd1);
      check("R1 word", word, {32'hA500_0000 + i, 32'h1000_0000 + i});
      check("R4 last", 64'(last), 64'(VEC[i][0]));
      check("R5 byte enable", 64'(byte_en), 64'(VEC[i][8:1]));
      check("R8 ready pending", 64'(ready), 64'd0);
      core_ready = 1'b1;
      @(negedge clk);
      core_ready = 1'b0;
      check("R7 valid drop", 64'(valid), 64'd0);
      check("R3 len step", 64'(len), 64'((l > 8) ? l - 8 : 0));
    end

    // R7 holds until accepted
    wr(3'd4, 32'd24);
    wr(3'd1, 32'h55);
    repeat (3) @(negedge clk);
    check("R7 hold unaccepted", 64'(valid), 64'd1);
    check("R3 no step without ready", 64'(len), 64'd24);
    core_ready = 1'b1;
    @(negedge clk);
    check("R8 ready after accept", 64'(ready), 64'd1);
    core_ready = 1'b0;

    // R6 constant fill to exhaustion
    wr(3'd2, 32'hC0DE_0001);
    check("R2 alt low no valid", 64'(valid), 64'd0);
    wr(3'd3, 32'hC0DE_0002);
    check("R2 alt high no valid", 64'(valid), 64'd0);
    wr(3'd4, 32'd20);
    wr(3'd5, 32'd1);
    check("R6 const valid", 64'(valid), 64'd1);
    check("R6 const word", word, 64'hC0DE_0002_C0DE_0001);
    check("R8 ready in const mode", 64'(ready), 64'd0);
    repeat (2) @(negedge clk);
    check("R6 hold while not ready", 64'(len), 64'd20);
    core_ready = 1'b1;
    @(negedge clk);
    check("R3 const step1", 64'(len), 64'd12);
    @(negedge clk);
    check("R4 const last", 64'(last), 64'd1);
    check("R5 const tail mask", 64'(byte_en), 64'h0F);
    @(negedge clk);
    check("R6 const done valid", 64'(valid), 64'd0);
    check("R3 const done len", 64'(len), 64'd0);
    repeat (2) @(negedge clk);
    check("R3 saturate", 64'(len), 64'd0);
    core_ready = 1'b0;

    // R9 abort mid-stream
    wr(3'd4, 32'd40);
    core_ready = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 before abort", 64'(len), 64'd24);
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'd0;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 valid off", 64'(valid), 64'd0);
    check("R9 len at abort", 64'(len), 64'd16);
    repeat (3) @(negedge clk);
    check("R9 len frozen", 64'(len), 64'd16);
    core_ready = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule